// File: doc/BRIEF.md
# Interrupt Message Acceptor with Processor Start-Up Sequencer

This block sits in front of one processor's interrupt controller and decides what to do with each incoming interrupt message. A message carries a 3-bit delivery mode, a vector, a trigger kind and an assert level. Depending on the mode, the block does one of the following:

- posts the vector to the request logic;
- raises a non-maskable notification;
- drops the message;
- flags the mode as illegal;
- steps the processor through its start-up handshake.

The start-up handshake has two steps. A reset-type message (INIT) moves a halted processor into a state where it waits for a start message. The start message then captures the entry vector and releases the processor.

The block also keeps three pieces of state. The first is an arbitration priority, bumped by every lowest-priority message. The second is the software enable of the controller. The third is the routing of local input 0. The software enable and the local-input routing both take their reset values from whether the instance is the boot processor. Every outcome is reported as a single-cycle registered pulse in the cycle after the message is sampled.

Top module: `irq_msg_acceptor`

## Requirements
- R1: Fixed mode (code 0) posts the vector (`post_valid` with `post_vector`) and pulses `accept` only when `hw_enable` and `sw_enabled` are both 1 when the message is sampled; otherwise nothing is posted and `accept` stays low.
- R2: Lowest-priority mode (code 1) is gated like fixed mode. It also adds 1 to `arb_prio` whether or not it is accepted, and the counter wraps modulo 2^ARB_W.
- R3: SMI mode (code 2) is dropped: no `accept`, no pulse of any kind, and no state change.
- R4: Remote-read mode (code 3) and NMI mode (code 4) pulse `accept` and `nmi_notify` and post no vector.
- R5: INIT mode (code 5) takes effect only when `msg_level_trig` is 0 (edge) or `msg_assert` is 1. A level-triggered message with `msg_assert` at 0 has no effect.
- R6: An effective INIT is ignored in run state. In any other state it:
  - pulses `accept`;
  - clears `sw_enabled` and `lint0_extint` to the non-boot reset values;
  - loads `arb_prio` with `phys_id`;
  - enters wait-for-start (`cpu_state` 1).
- R7: Start mode (code 6) in wait-for-start:
  - captures the vector into `start_vector`;
  - pulses `start_cpu` and `accept` for one cycle;
  - moves to run (`cpu_state` 2).
- R8: Start mode in any other state is not accepted and changes no state. In idle (`cpu_state` 0) it also pulses `startup_error`.
- R9: External-interrupt mode (code 7) pulses `illegal_mode` and is not accepted.
- R10: After reset `arb_prio` is 0, and the other reset values depend on the instance:

  | Instance | `cpu_state` | `sw_enabled` | `lint0_extint` |
  |----------|-------------|--------------|----------------|
  | Boot (IS_BOOT=1) | 2 (run) | 1 | 1 |
  | Non-boot | 0 (idle) | 0 | 0 |

- R11: All result outputs are registered pulses that appear one cycle after `msg_valid` is sampled and last one cycle. At most one of `post_valid`, `nmi_notify` and `start_cpu` is high at a time.
- R12: A cycle with `swen_wr` high loads `sw_enabled` from `swen_val` unless an effective INIT is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_enable | input | 1 | Hardware enable of the controller |
| phys_id | input | ID_W | Physical identifier loaded into arbitration priority by INIT |
| swen_wr | input | 1 | Write strobe for the software enable |
| swen_val | input | 1 | Value for the software enable |
| msg_valid | input | 1 | Message present this cycle |
| msg_mode | input | 3 | Delivery mode code |
| msg_vector | input | VEC_W | Message vector |
| msg_level_trig | input | 1 | 1 = level-triggered, 0 = edge |
| msg_assert | input | 1 | Assert level of the message |
| accept | output | 1 | Message accepted pulse |
| post_valid | output | 1 | Vector posted pulse |
| post_vector | output | VEC_W | Posted vector |
| nmi_notify | output | 1 | Non-maskable notification pulse |
| start_cpu | output | 1 | Start-processor pulse |
| start_vector | output | VEC_W | Captured start vector |
| illegal_mode | output | 1 | Illegal delivery mode pulse |
| startup_error | output | 1 | Start message received while idle |
| cpu_state | output | 2 | 0 idle, 1 wait-for-start, 2 run |
| sw_enabled | output | 1 | Software enable of the controller |
| lint0_extint | output | 1 | Local input 0 routed as external interrupt |
| arb_prio | output | ARB_W | Arbitration priority |

## Verification
The hardest cases to reach from the ports all need a non-boot instance held in specific states. The level-deasserted INIT must be sent while the processor is still idle, because once in run state every INIT is ignored anyway and the check would prove nothing. The start-while-idle error needs the same idle processor. Arbitration wrap-around needs an INIT that loads a physical identifier just below the top of the counter, followed by two lowest-priority messages: one with the software enable off and one with it on. The stimulus therefore follows a fixed order: probe the idle state first, then INIT, then start, then run-state rejection, and only then enable the controller for posting.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

   typedef enum logic [2:0] {
      DM_FIXED   = 3'd0,
      DM_LOWEST  = 3'd1,
      DM_SMI     = 3'd2,
      DM_REMRD   = 3'd3,
      DM_NMI     = 3'd4,
      DM_INIT    = 3'd5,
      DM_STARTUP = 3'd6,
      DM_EXTINT  = 3'd7
   } dmode_e;

   typedef enum logic [2:0] {
      CL_POST,
      CL_NOTIFY,
      CL_DROP,
      CL_INIT,
      CL_START,
      CL_ILLEGAL
   } mcls_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } cpu_st_e;

   typedef struct packed {
      mcls_e cls;
      logic  bump;
   } dec_t;

endpackage

// File: rtl/irq_mode_decode.sv
module irq_mode_decode
   import irq_acc_pkg::*;
(
   input  logic [2:0] mode_i,
   output dec_t       dec_o
);

   always_comb begin
      dec_o.bump = 1'b0;
      unique case (dmode_e'(mode_i))
         DM_FIXED:   dec_o.cls = CL_POST;
         DM_LOWEST: begin
            dec_o.cls  = CL_POST;
            dec_o.bump = 1'b1;
         end
         DM_SMI:     dec_o.cls = CL_DROP;
         DM_REMRD:   dec_o.cls = CL_NOTIFY;
         DM_NMI:     dec_o.cls = CL_NOTIFY;
         DM_INIT:    dec_o.cls = CL_INIT;
         DM_STARTUP: dec_o.cls = CL_START;
         default:    dec_o.cls = CL_ILLEGAL;
      endcase
   end

endmodule

// File: rtl/irq_arb_counter.sv
module irq_arb_counter #(
   parameter int ARB_W = 8,
   parameter int ID_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [ID_W-1:0]  load_val_i,
   input  logic             bump_i,
   output logic [ARB_W-1:0] arb_o
);

   logic [ARB_W-1:0] load_ext;

   generate
      if (ARB_W >= ID_W) begin : g_zext
         localparam int PAD_W = ARB_W - ID_W;
         if (PAD_W > 0) begin : g_pad
            assign load_ext = {{PAD_W{1'b0}}, load_val_i};
         end else begin : g_same
            assign load_ext = load_val_i;
         end
      end else begin : g_trunc
         assign load_ext = load_val_i[ARB_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arb_o <= '0;
      end else if (load_i) begin
         arb_o <= load_ext;
      end else if (bump_i) begin
         arb_o <= arb_o + ARB_W'(1);
      end
   end

endmodule

// File: rtl/irq_startup_fsm.sv
module irq_startup_fsm
   import irq_acc_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter bit IS_BOOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  mcls_e            cls_i,
   input  logic             lvl_trig_i,
   input  logic             assert_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic             swen_we_i,
   input  logic             swen_d_i,
   output cpu_st_e          st_o,
   output logic             sw_en_o,
   output logic             lint0_ext_o,
   output logic [VEC_W-1:0] start_vec_o,
   output logic             init_go_o,
   output logic             start_ok_o,
   output logic             start_err_o
);

   localparam cpu_st_e ST_RESET  = IS_BOOT ? ST_RUN : ST_IDLE;
   localparam logic    SWEN_RST  = IS_BOOT;
   localparam logic    LINT_RST  = IS_BOOT;

   logic init_effective;

   assign init_effective = fire_i && (cls_i == CL_INIT) && (!lvl_trig_i || assert_i);
   assign init_go_o      = init_effective && (st_o != ST_RUN);
   assign start_ok_o     = fire_i && (cls_i == CL_START) && (st_o == ST_WAIT);
   assign start_err_o    = fire_i && (cls_i == CL_START) && (st_o == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_o        <= ST_RESET;
         sw_en_o     <= SWEN_RST;
         lint0_ext_o <= LINT_RST;
         start_vec_o <= '0;
      end else begin
         if (init_go_o) begin
            st_o        <= ST_WAIT;
            sw_en_o     <= SWEN_RST;
            lint0_ext_o <= LINT_RST;
         end else begin
            if (swen_we_i) begin
               sw_en_o <= swen_d_i;
            end
            if (start_ok_o) begin
               st_o        <= ST_RUN;
               start_vec_o <= vec_i;
            end
         end
      end
   end

endmodule

// File: rtl/irq_msg_acceptor.sv
module irq_msg_acceptor
   import irq_acc_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int ID_W    = 8,
   parameter int ARB_W   = 8,
   parameter bit IS_BOOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_enable,
   input  logic [ID_W-1:0]  phys_id,
   input  logic             swen_wr,
   input  logic             swen_val,
   input  logic             msg_valid,
   input  logic [2:0]       msg_mode,
   input  logic [VEC_W-1:0] msg_vector,
   input  logic             msg_level_trig,
   input  logic             msg_assert,
   output logic             accept,
   output logic             post_valid,
   output logic [VEC_W-1:0] post_vector,
   output logic             nmi_notify,
   output logic             start_cpu,
   output logic [VEC_W-1:0] start_vector,
   output logic             illegal_mode,
   output logic             startup_error,
   output logic [1:0]       cpu_state,
   output logic             sw_enabled,
   output logic             lint0_extint,
   output logic [ARB_W-1:0] arb_prio
);

   generate
      if (VEC_W < 4 || VEC_W > 16) begin : g_bad_vec
         $error("VEC_W must lie in 4..16");
      end
      if (ID_W < 1 || ID_W > 32) begin : g_bad_id
         $error("ID_W must lie in 1..32");
      end
      if (ARB_W < 2 || ARB_W > 32) begin : g_bad_arb
         $error("ARB_W must lie in 2..32");
      end
   endgenerate

   dec_t    dec;
   cpu_st_e st;
   logic    init_go, start_ok, start_err;
   logic    post_ok, notify_ok, illegal_hit, acc_d, bump;

   irq_mode_decode u_dec (
      .mode_i (msg_mode),
      .dec_o  (dec)
   );

   irq_startup_fsm #(
      .VEC_W   (VEC_W),
      .IS_BOOT (IS_BOOT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (msg_valid),
      .cls_i       (dec.cls),
      .lvl_trig_i  (msg_level_trig),
      .assert_i    (msg_assert),
      .vec_i       (msg_vector),
      .swen_we_i   (swen_wr),
      .swen_d_i    (swen_val),
      .st_o        (st),
      .sw_en_o     (sw_enabled),
      .lint0_ext_o (lint0_extint),
      .start_vec_o (start_vector),
      .init_go_o   (init_go),
      .start_ok_o  (start_ok),
      .start_err_o (start_err)
   );

   assign bump = msg_valid && dec.bump;

   irq_arb_counter #(
      .ARB_W (ARB_W),
      .ID_W  (ID_W)
   ) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (init_go),
      .load_val_i (phys_id),
      .bump_i     (bump),
      .arb_o      (arb_prio)
   );

   assign post_ok     = msg_valid && (dec.cls == CL_POST) && hw_enable && sw_enabled;
   assign notify_ok   = msg_valid && (dec.cls == CL_NOTIFY);
   assign illegal_hit = msg_valid && (dec.cls == CL_ILLEGAL);
   assign acc_d       = post_ok || notify_ok || init_go || start_ok;
   assign cpu_state   = st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         accept        <= 1'b0;
         post_valid    <= 1'b0;
         post_vector   <= '0;
         nmi_notify    <= 1'b0;
         start_cpu     <= 1'b0;
         illegal_mode  <= 1'b0;
         startup_error <= 1'b0;
      end else begin
         accept        <= acc_d;
         post_valid    <= post_ok;
         nmi_notify    <= notify_ok;
         start_cpu     <= start_ok;
         illegal_mode  <= illegal_hit;
         startup_error <= start_err;
         if (post_ok) begin
            post_vector <= msg_vector;
         end
      end
   end

endmodule

// File: rtl/irq_msg_acceptor_chk.sv
module irq_msg_acceptor_chk #(
   parameter int VEC_W = 8,
   parameter int ARB_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_enable,
   input logic             msg_valid,
   input logic [2:0]       msg_mode,
   input logic [VEC_W-1:0] msg_vector,
   input logic             accept,
   input logic             post_valid,
   input logic             nmi_notify,
   input logic             start_cpu,
   input logic [VEC_W-1:0] start_vector,
   input logic             illegal_mode,
   input logic             startup_error,
   input logic [1:0]       cpu_state,
   input logic             sw_enabled,
   input logic [ARB_W-1:0] arb_prio
);

   AST_POST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |-> $past(hw_enable && sw_enabled && msg_valid)); // R1

   AST_LOWEST_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_mode == 3'd1) |=> ((arb_prio - $past(arb_prio)) == ARB_W'(1))); // R2

   AST_SMI_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_mode == 3'd2) |=> (!accept && !post_valid && !nmi_notify)); // R3

   AST_INIT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_mode == 3'd5 && cpu_state == 2'd2)
      |=> (cpu_state == 2'd2 && $stable(arb_prio) && !accept)); // R6

   AST_START_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      start_cpu |-> ($past(cpu_state) == 2'd1 && cpu_state == 2'd2
                     && start_vector == $past(msg_vector))); // R7

   AST_START_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_mode == 3'd6 && cpu_state == 2'd0)
      |=> (startup_error && !accept && cpu_state == 2'd0)); // R8

   AST_EXTINT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_mode == 3'd7) |=> (illegal_mode && !accept)); // R9

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({post_valid, nmi_notify, start_cpu})); // R11

endmodule

bind irq_msg_acceptor irq_msg_acceptor_chk #(
   .VEC_W (VEC_W),
   .ARB_W (ARB_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hw_enable     (hw_enable),
   .msg_valid     (msg_valid),
   .msg_mode      (msg_mode),
   .msg_vector    (msg_vector),
   .accept        (accept),
   .post_valid    (post_valid),
   .nmi_notify    (nmi_notify),
   .start_cpu     (start_cpu),
   .start_vector  (start_vector),
   .illegal_mode  (illegal_mode),
   .startup_error (startup_error),
   .cpu_state     (cpu_state),
   .sw_enabled    (sw_enabled),
   .arb_prio      (arb_prio)
);

// File: tb/irq_msg_acceptor_tb.sv
module irq_msg_acceptor_tb;

   localparam int VEC_W = 8;
   localparam int ID_W  = 8;
   localparam int ARB_W = 8;
   localparam logic [ID_W-1:0] PID = 8'hFE;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             hw_enable = 1'b0;
   logic             swen_wr = 1'b0, swen_val = 1'b0;
   logic             msg_valid = 1'b0;
   logic [2:0]       msg_mode = 3'd0;
   logic [VEC_W-1:0] msg_vector = '0;
   logic             msg_level_trig = 1'b0, msg_assert = 1'b0;

   logic             accept, post_valid, nmi_notify, start_cpu, illegal_mode, startup_error;
   logic [VEC_W-1:0] post_vector, start_vector;
   logic [1:0]       cpu_state;
   logic             sw_enabled, lint0_extint;
   logic [ARB_W-1:0] arb_prio;

   logic             b_accept, b_post, b_nmi, b_start, b_ill, b_serr;
   logic [VEC_W-1:0] b_pvec, b_svec;
   logic [1:0]       b_state;
   logic             b_sw, b_lint;
   logic [ARB_W-1:0] b_arb;

   irq_msg_acceptor #(.VEC_W(VEC_W), .ID_W(ID_W), .ARB_W(ARB_W), .IS_BOOT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .hw_enable(hw_enable), .phys_id(PID),
      .swen_wr(swen_wr), .swen_val(swen_val), .msg_valid(msg_valid),
      .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_level_trig(msg_level_trig),
      .msg_assert(msg_assert), .accept(accept), .post_valid(post_valid),
      .post_vector(post_vector), .nmi_notify(nmi_notify), .start_cpu(start_cpu),
      .start_vector(start_vector), .illegal_mode(illegal_mode),
      .startup_error(startup_error), .cpu_state(cpu_state), .sw_enabled(sw_enabled),
      .lint0_extint(lint0_extint), .arb_prio(arb_prio)
   );

   irq_msg_acceptor #(.VEC_W(VEC_W), .ID_W(ID_W), .ARB_W(ARB_W), .IS_BOOT(1'b1)) u_boot (
      .clk(clk), .rst_n(rst_n), .hw_enable(1'b1), .phys_id(8'h00),
      .swen_wr(1'b0), .swen_val(1'b0), .msg_valid(1'b0),
      .msg_mode(3'd0), .msg_vector(8'h00), .msg_level_trig(1'b0),
      .msg_assert(1'b0), .accept(b_accept), .post_valid(b_post),
      .post_vector(b_pvec), .nmi_notify(b_nmi), .start_cpu(b_start),
      .start_vector(b_svec), .illegal_mode(b_ill),
      .startup_error(b_serr), .cpu_state(b_state), .sw_enabled(b_sw),
      .lint0_extint(b_lint), .arb_prio(b_arb)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    due;
      string tag;
      logic [39:0] obs;
   } exp_t;

   exp_t q[$];
   exp_t it;

   // model state
   logic [1:0]       m_state = 2'd0;
   logic             m_sw = 1'b0, m_lint = 1'b0;
   logic [ARB_W-1:0] m_arb = '0;
   logic [VEC_W-1:0] m_svec = '0, m_pvec = '0;

   function automatic logic [39:0] pack_obs(logic a, logic p, logic [7:0] pv, logic n, logic s,
                                            logic [7:0] sv, logic il, logic se, logic [1:0] st,
                                            logic sw, logic li, logic [7:0] ar);
      return {a, p, pv, n, s, sv, il, se, st, sw, li, ar, 4'h0};
   endfunction

   function automatic logic [39:0] dut_obs();
      return pack_obs(accept, post_valid, post_vector, nmi_notify, start_cpu, start_vector,
                      illegal_mode, startup_error, cpu_state, sw_enabled, lint0_extint, arb_prio);
   endfunction

   task automatic check(string tag, logic [39:0] got, logic [39:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due <= cyc) begin
         it = q.pop_front();
         check(it.tag, dut_obs(), it.obs);
      end
   end

   task automatic push(string tag, logic a, logic p, logic n, logic s, logic il, logic se);
      exp_t e;
      e.due = cyc + 1;
      e.tag = tag;
      e.obs = pack_obs(a, p, m_pvec, n, s, m_svec, il, se, m_state, m_sw, m_lint, m_arb);
      q.push_back(e);
   endtask

   // driver: one message, then an idle cycle checking the pulses dropped (R11)
   task automatic send(string tag, logic [2:0] mode, logic [7:0] vec, logic lt, logic asrt);
      logic a = 0, p = 0, n = 0, s = 0, il = 0, se = 0;
      @(negedge clk);
      msg_valid = 1'b1; msg_mode = mode; msg_vector = vec;
      msg_level_trig = lt; msg_assert = asrt;
      case (mode)
         3'd0, 3'd1: begin
            if (mode == 3'd1) m_arb = m_arb + 8'd1;
            if (hw_enable && m_sw) begin a = 1; p = 1; m_pvec = vec; end
         end
         3'd3, 3'd4: begin a = 1; n = 1; end
         3'd5: if ((!lt || asrt) && m_state != 2'd2) begin
            a = 1; m_sw = 0; m_lint = 0; m_arb = PID; m_state = 2'd1;
         end
         3'd6: begin
            if (m_state == 2'd1) begin a = 1; s = 1; m_svec = vec; m_state = 2'd2; end
            else if (m_state == 2'd0) se = 1;
         end
         3'd7: il = 1;
         default: ;
      endcase
      push(tag, a, p, n, s, il, se);
      @(negedge clk);
      msg_valid = 1'b0;
      push({tag, " R11 pulse end"}, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic write_swen(logic v);
      @(negedge clk);
      swen_wr = 1'b1; swen_val = v;
      m_sw = v;
      push("R12 sw enable write", 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      swen_wr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset values
      check("R10 nonboot reset", dut_obs(), pack_obs(0,0,8'h00,0,0,8'h00,0,0,2'd0,0,0,8'h00));
      check("R10 boot reset", {b_state, b_sw, b_lint, b_arb, b_accept},
            {2'd2, 1'b1, 1'b1, 8'h00, 1'b0});

      hw_enable = 1'b1;
      send("R1 fixed sw disabled", 3'd0, 8'h41, 0, 0);
      send("R8 start while idle", 3'd6, 8'h9A, 0, 0);
      send("R5 level deassert INIT", 3'd5, 8'h00, 1, 0);
      send("R5 R6 level assert INIT", 3'd5, 8'h00, 1, 1);
      send("R6 INIT in wait reloads", 3'd5, 8'h00, 0, 0);
      send("R7 start in wait", 3'd6, 8'h9A, 0, 0);
      send("R8 start in run", 3'd6, 8'h33, 0, 0);
      send("R6 INIT in run ignored", 3'd5, 8'h00, 0, 0);
      send("R2 lowest disabled bump", 3'd1, 8'h52, 0, 0);
      write_swen(1'b1);
      send("R2 lowest accepted wrap", 3'd1, 8'h53, 0, 0);
      send("R1 fixed posted", 3'd0, 8'h64, 0, 0);
      hw_enable = 1'b0;
      send("R1 fixed hw disabled", 3'd0, 8'h65, 0, 0);
      hw_enable = 1'b1;
      send("R3 SMI dropped", 3'd2, 8'h70, 0, 0);
      send("R4 NMI", 3'd4, 8'h02, 0, 0);
      send("R4 remote read", 3'd3, 8'h03, 0, 0);
      send("R9 extint illegal", 3'd7, 8'h20, 0, 0);
      write_swen(1'b0);
      send("R1 fixed after disable", 3'd0, 8'h66, 0, 0);

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule